// File: doc/BRIEF.md
# Radix-10 Digit-Recurrence Divider

This block divides one BCD integer by another. It produces one signed decimal quotient digit per clock cycle. The divisor is normalized: its leading BCD digit is non-zero, so its value read as a fraction lies in [0.1, 1). The dividend is any BCD value of the same width. The quotient is `floor(dividend * 10^NDIG / divisor)` and needs NDIG+2 BCD digits. The remainder is the matching non-negative integer remainder, less than the divisor, in NDIG BCD digits.

Every quotient digit is the sum of two subdigits:
- a radix-5 subdigit `qH` in {-1,0,1}, which carries weight five;
- a radix-2 subdigit `qL` in {-2..2}.

The two subdigits together give a digit in -7..7. Each iteration subtracts `5*qH*d` first and `qL*d` second. The only multiples of the divisor it forms are 1x, 2x and 5x, and these come from shifts and one add.

The first residual is the dividend scaled down by 100 relative to the divisor. This keeps it inside the convergence bound. The signed digits are turned into plain BCD on the fly, using a pair of registers that hold Q and Q-1. A negative final residual selects Q-1 and adds the divisor back to the remainder.

A caller applies the operands and pulses `start` for one cycle. It reads `quotient` and `remainder` in the cycle in which `done` pulses.

Top module: `dec_div_top`

## Requirements
- R1: In the cycle in which `done` is high, `quotient` equals floor(X*10^NDIG/D) as NDIG+2 BCD digits. Digit i sits at bits [4i+3:4i], with the least significant digit at bit 0. X and D are the integer values of the BCD inputs, with the same digit layout.
- R2: In the cycle in which `done` is high, `remainder` equals X*10^NDIG - Q*D as NDIG BCD digits, and it lies in [0, D). This holds also when the last residual was negative.
- R3: `done` is high for exactly one cycle. It is registered high by the NDIG+3rd rising edge after the edge that samples `start` high.
- R4: A `start` pulse while a division is running is ignored. The running division keeps its operands, its result and its `done` timing.
- R5: Each quotient digit is 5*qH+qL with qH in {-1,0,1} and qL in {-2..2}. Before every iteration the residual magnitude is at most 0.75 of 100*D.
- R6: After reset, `done` is 0 and `quotient` and `remainder` are all zero.
- R7: `quotient` and `remainder` hold their values, and `done` stays low, until the next division completes.
- R8: A zero dividend gives a zero quotient and a zero remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; operands are sampled at the same edge |
| dividend | input | 4*NDIG | BCD dividend X |
| divisor | input | 4*NDIG | BCD divisor D, leading digit non-zero |
| done | output | 1 | One-cycle pulse when the result is valid |
| quotient | output | 4*(NDIG+2) | BCD quotient |
| remainder | output | 4*NDIG | BCD remainder |

## Verification
- **Result timing.** Results are due NDIG+3 rising edges after the edge that samples `start`. That edge loads the operands, NDIG+2 edges run the iterations, and one edge performs the correction and registers the outputs.
- **Where the bench samples.** The bench drives inputs on falling edges and samples on falling edges. It checks that `done` is still low after NDIG+2 edges and high after NDIG+3, and reads the results in that same half cycle.
- **Sweep.** With NDIG=2, the bench covers every normalized divisor against every dividend.
- **Stability and busy checks.** Further checks look a few cycles after `done` to confirm the outputs hold. Another check injects a second `start` in mid-run and confirms that the first operands' result still arrives at the original edge.

// File: rtl/dec_div_pkg.sv
package dec_div_pkg;

  typedef struct packed {
    logic load;    // sample operands, clear converter
    logic step;    // run one recurrence iteration
    logic finish;  // correct sign and register outputs
  } dpCtrl_t;

  // BCD (least significant digit at bit 0) to integer
  function automatic longint bcdToBin(input logic [63:0] v, input int nd);
    longint acc;
    acc = 0;
    for (int i = nd - 1; i >= 0; i--) begin
      acc = acc * 10 + longint'(v[4*i +: 4]);
    end
    return acc;
  endfunction

  // non-negative integer to BCD
  function automatic logic [63:0] binToBcd(input longint x, input int nd);
    logic [63:0] r;
    longint t;
    r = '0;
    t = x;
    for (int i = 0; i < nd; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/dec_div_ctrl.sv
module dec_div_ctrl
  import dec_div_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output dpCtrl_t ctl,
  output logic    done
);

  localparam int QD = NDIG + 2;
  localparam int CW = $clog2(QD + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t state;
  logic [CW-1:0] iterCnt;

  always_comb begin
    ctl.load   = (state == S_IDLE) && start;
    ctl.step   = (state == S_RUN);
    ctl.finish = (state == S_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_RUN;
          iterCnt <= '0;
        end
        S_RUN: begin
          if (iterCnt == CW'(QD - 1)) state <= S_FIN;
          else iterCnt <= iterCnt + 1'b1;
        end
        S_FIN: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // latency counter used only by the checks below
  logic [7:0] sinceLoad;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceLoad <= 8'hff;
    else if (ctl.load) sinceLoad <= '0;
    else if (sinceLoad != 8'hff) sinceLoad <= sinceLoad + 1'b1;
  end

  a_r3_done_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_done_latency: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> sinceLoad == 8'(QD + 1));

  a_r4_busy_keeps_counting: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && iterCnt != CW'(QD - 1)) |=>
      (state == S_RUN && iterCnt == $past(iterCnt) + 1'b1));

endmodule

// File: rtl/dec_div_datapath.sv
module dec_div_datapath
  import dec_div_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               ctl,
  input  logic [4*NDIG-1:0]     dividend,
  input  logic [4*NDIG-1:0]     divisor,
  output logic [4*(NDIG+2)-1:0] quotient,
  output logic [4*NDIG-1:0]     remainder
);

  localparam int     QD    = NDIG + 2;
  localparam longint SPAN  = longint'(200) * (longint'(10) ** (NDIG + 2));
  localparam int     WW    = $clog2(SPAN) + 2;
  localparam longint QMOD  = longint'(10) ** QD;

  logic signed [WW-1:0] resid, dBin;
  logic [4*QD-1:0]      qAcc, qmAcc;

  // divisor multiples: scaled divisor D' = 100*D, then 2x and 5x by shift/add
  logic signed [WW-1:0] dBig, dBig2, dBig3, dBig5;
  assign dBig  = dBin * WW'(100);
  assign dBig2 = dBig <<< 1;
  assign dBig3 = dBig2 + dBig;
  assign dBig5 = (dBig <<< 2) + dBig;

  // stage 1: radix-5 subdigit on 10*w
  logic signed [WW-1:0] vRes, vTwice, uRes, uTwice, wNext;
  logic signed [2:0]    qH, qL;
  logic signed [4:0]    qDig;

  always_comb begin
    vRes   = (resid <<< 3) + (resid <<< 1);
    vTwice = vRes <<< 1;
    if (vTwice >= dBig5) begin
      qH = 3'sd1;  uRes = vRes - dBig5;
    end else if (vTwice < -dBig5) begin
      qH = -3'sd1; uRes = vRes + dBig5;
    end else begin
      qH = 3'sd0;  uRes = vRes;
    end
  end

  // stage 2: radix-2 subdigit on the partial residual
  always_comb begin
    uTwice = uRes <<< 1;
    if (uTwice >= dBig3) begin
      qL = 3'sd2;  wNext = uRes - dBig2;
    end else if (uTwice >= dBig) begin
      qL = 3'sd1;  wNext = uRes - dBig;
    end else if (uTwice >= -dBig) begin
      qL = 3'sd0;  wNext = uRes;
    end else if (uTwice >= -dBig3) begin
      qL = -3'sd1; wNext = uRes + dBig;
    end else begin
      qL = -3'sd2; wNext = uRes + dBig2;
    end
    qDig = (5'(qH) <<< 2) + 5'(qH) + 5'(qL);
  end

  // on-the-fly conversion to plain BCD: Q and Q-1 kept side by side
  logic [3:0] nibQ, nibQm;
  always_comb begin
    nibQ  = (qDig >= 0) ? qDig[3:0] : 4'(qDig + 5'sd10);
    nibQm = (qDig > 0)  ? 4'(qDig - 5'sd1) : 4'(qDig + 5'sd9);
  end

  // final sign correction
  logic signed [WW-1:0] remRaw, remFix;
  logic [63:0]          remBcd;
  logic                 negFinal;
  always_comb begin
    negFinal = resid < 0;
    remRaw   = resid / WW'(100);
    remFix   = negFinal ? remRaw + dBin : remRaw;
    remBcd   = binToBcd(longint'(remFix), NDIG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resid     <= '0;
      dBin      <= '0;
      qAcc      <= '0;
      qmAcc     <= '0;
      quotient  <= '0;
      remainder <= '0;
    end else if (ctl.load) begin
      resid <= WW'(bcdToBin(64'(dividend), NDIG));
      dBin  <= WW'(bcdToBin(64'(divisor), NDIG));
      qAcc  <= '0;
      qmAcc <= {QD{4'h9}};
    end else if (ctl.step) begin
      resid <= wNext;
      qAcc  <= (qDig >= 0) ? {qAcc[4*QD-5:0], nibQ} : {qmAcc[4*QD-5:0], nibQ};
      qmAcc <= (qDig > 0)  ? {qAcc[4*QD-5:0], nibQm} : {qmAcc[4*QD-5:0], nibQm};
    end else if (ctl.finish) begin
      quotient  <= negFinal ? qmAcc : qAcc;
      remainder <= remBcd[4*NDIG-1:0];
    end
  end

  logic signed [WW-1:0] residMag;
  assign residMag = (resid < 0) ? -resid : resid;

  a_r5_residual_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> (residMag <<< 2) <= dBig3);

  a_r5_digit_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> (qDig >= -5'sd7 && qDig <= 5'sd7));

  a_r1_otf_pair: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> ((bcdToBin(64'(qmAcc), QD) + 1) % QMOD) == bcdToBin(64'(qAcc), QD));

  a_r2_remainder_below_divisor: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> bcdToBin(64'(remainder), NDIG) < longint'(dBin));

endmodule

// File: rtl/dec_div_top.sv
module dec_div_top
  import dec_div_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [4*NDIG-1:0]     dividend,
  input  logic [4*NDIG-1:0]     divisor,
  output logic                  done,
  output logic [4*(NDIG+2)-1:0] quotient,
  output logic [4*NDIG-1:0]     remainder
);

  dpCtrl_t ctl;

  dec_div_ctrl #(.NDIG(NDIG)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  dec_div_datapath #(.NDIG(NDIG)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder)
  );

endmodule

// File: tb/tb_dec_div_top.sv
module tb_dec_div_top;

  localparam int NDIG = 2;
  localparam int QD   = NDIG + 2;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic [4*NDIG-1:0]   dividend = '0;
  logic [4*NDIG-1:0]   divisor = '0;
  logic                done;
  logic [4*QD-1:0]     quotient;
  logic [4*NDIG-1:0]   remainder;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dec_div_top #(.NDIG(NDIG)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .dividend(dividend), .divisor(divisor),
    .done(done), .quotient(quotient), .remainder(remainder)
  );

  function automatic logic [63:0] toBcd(input longint x);
    logic [63:0] r;
    longint t;
    r = '0;
    t = x;
    for (int i = 0; i < 16; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // full division: start pulse, timing of done, results
  task automatic runCase(input int x, input int d, input bit intrude);
    longint qExp, rExp;
    qExp = (longint'(x) * 100) / d;
    rExp = (longint'(x) * 100) % d;
    @(negedge clk);
    dividend = toBcd(x)[4*NDIG-1:0];
    divisor  = toBcd(d)[4*NDIG-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= QD; i++) begin
      @(negedge clk);
      if (intrude && i == 2) begin
        dividend = toBcd((x + 37) % 100)[4*NDIG-1:0];
        divisor  = toBcd(99)[4*NDIG-1:0];
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (i == QD) check(intrude ? "R4 done early" : "R3 done early", longint'(done), 0);
    end
    start = 1'b0;
    @(negedge clk);
    check(intrude ? "R4 done timing" : "R3 done timing", longint'(done), 1);
    check(intrude ? "R4 quotient" : "R1 quotient", longint'(quotient), longint'(toBcd(qExp)[4*QD-1:0]));
    check(intrude ? "R4 remainder" : "R2 remainder", longint'(remainder), longint'(toBcd(rExp)[4*NDIG-1:0]));
    if (x == 0) begin
      check("R8 zero quotient", longint'(quotient), 0);
      check("R8 zero remainder", longint'(remainder), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R3 watchdog: no completion, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4*QD-1:0]   qHold;
    logic [4*NDIG-1:0] rHold;
    repeat (3) @(negedge clk);
    // R6 reset values
    check("R6 done", longint'(done), 0);
    check("R6 quotient", longint'(quotient), 0);
    check("R6 remainder", longint'(remainder), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1, R2, R3, R8: every normalized divisor against every dividend
    for (int d = 10; d <= 99; d++) begin
      for (int x = 0; x <= 99; x++) begin
        runCase(x, d, 1'b0);
      end
    end

    // R7: outputs hold after completion
    runCase(97, 13, 1'b0);
    qHold = quotient;
    rHold = remainder;
    repeat (4) begin
      @(negedge clk);
      check("R7 done low", longint'(done), 0);
      check("R7 quotient held", longint'(quotient), longint'(qHold));
      check("R7 remainder held", longint'(remainder), longint'(rHold));
    end

    // R4: start in mid-run is ignored
    runCase(88, 11, 1'b1);
    runCase(5, 97, 1'b1);
    runCase(99, 10, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule